// File: doc/BRIEF.md
# Flash Write Burst Splitter

This block takes one flash write request, given as a start chip, a byte offset inside that chip and a byte length. It turns the request into a series of buffered-program bursts. Each burst stays inside one aligned write-buffer window. Burst commands leave on a valid/ready channel. After each one the block waits for the flash engine to report completion and status before it plans the next burst. When the data left is shorter than two bus words, that tail goes to a single-word write channel as one request. The block then reports the final status and the number of bytes written.

The caller keeps the start offset aligned to the bus width and below the per-chip size. The `*_src` outputs give the byte index into the caller's source buffer, which is the count of bytes already written, so the data path can fetch the matching data. Back-pressure rules for both request channels are the same. Once a channel raises valid, it holds valid and every field stable until the cycle in which ready is high, and that cycle is the transfer. After a transfer the block sends nothing more until the matching done pulse arrives, so at most one request is in flight.

Top module: `flash_burst_splitter`

## Requirements
- R1: After reset, `busy`, `burst_valid`, `word_valid` and `done` are all low.
- R2: `start` is taken only while `busy` is low. A `start` pulse while busy is ignored and does not change the bursts or the result of the operation in progress.
- R3: A burst is issued only while the remaining length is at least 2×BUS_BYTES bytes.
- R4: Burst size is taken from BUF_BYTES − (offset mod BUF_BYTES). It is clipped to the remaining length and then rounded down to a multiple of BUS_BYTES. So a burst never crosses a BUF_BYTES-aligned window, and its size is a nonzero multiple of BUS_BYTES.
- R5: On both channels, valid holds with stable fields until ready. The two valids are never high together. No new request appears until the previous one has received its done pulse.
- R6: After a burst completes without error, the offset and the source index advance by the burst size, the remaining length drops by it, and the completed count grows by it.
- R7: When the offset reaches 2^CHIP_AW, the chip index increments and the offset returns to 0.
- R8: When the chip index reaches NUM_CHIPS, the operation ends successfully with no further bursts and no tail request. Every issued chip index is below NUM_CHIPS.
- R9: A burst done with `burst_err` high ends the operation at once with `done_err` high. The failed burst is not counted, and no further request is made.
- R10: A nonzero remainder shorter than 2×BUS_BYTES goes out as exactly one word-channel request with the current chip, offset, source index and remaining length. The returned `word_count` is added to the total, and `word_err` becomes the final status.
- R11: `done` is a single-cycle pulse carrying `done_err` and `done_count`. A zero-length request finishes with count 0 and no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| start_chip | input | CHIP_W | First chip index |
| start_ofs | input | CHIP_AW | Byte offset in the first chip (bus aligned) |
| start_len | input | LEN_W | Bytes to write |
| busy | output | 1 | Operation in progress |
| burst_valid | output | 1 | Burst command valid |
| burst_ready | input | 1 | Burst command accepted |
| burst_chip | output | CHIP_W | Burst chip index |
| burst_ofs | output | CHIP_AW | Burst byte offset |
| burst_size | output | SIZE_W | Burst byte count |
| burst_src | output | LEN_W | Source byte index of the burst |
| burst_done | input | 1 | Burst finished pulse |
| burst_err | input | 1 | Burst failed (with burst_done) |
| word_valid | output | 1 | Tail request valid |
| word_ready | input | 1 | Tail request accepted |
| word_chip | output | CHIP_W | Tail chip index |
| word_ofs | output | CHIP_AW | Tail byte offset |
| word_len | output | LEN_W | Tail byte count |
| word_src | output | LEN_W | Source byte index of the tail |
| word_done | input | 1 | Tail finished pulse |
| word_err | input | 1 | Tail failed (with word_done) |
| word_count | input | LEN_W | Bytes the tail path wrote |
| done | output | 1 | Operation finished pulse |
| done_err | output | 1 | Final status, valid with done |
| done_count | output | LEN_W | Bytes written, valid with done |

## Verification
The assertions check every cycle that a burst never spans a buffer window and that its size is a nonzero whole number of bus words. They also check that both channels hold valid with stable fields under back-pressure, that the channels never overlap, that chip indices stay in range, that tails are shorter than two words, and that done lasts one cycle. Other behaviour shows only in the bench's scenarios: the exact sequence of burst sizes, the carry of offset across chip boundaries, the early end at the last chip, error abort counts, the addition of the tail count, and the rejection of a start given mid-operation. Those need whole operations compared against the reference model.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_BURST,
    ST_BWAIT,
    ST_WORD,
    ST_WWAIT,
    ST_FIN
  } fbs_state_t;
endpackage

// File: rtl/fbs_sizer.sv
// Works out the size of the next burst from the window position and the bytes left.
module fbs_sizer #(
  parameter int BUF_BYTES = 32,
  parameter int BUS_BYTES = 2,
  parameter int CHIP_AW   = 8,
  parameter int LEN_W     = 16,
  localparam int LOW_W    = $clog2(BUF_BYTES),
  localparam int SIZE_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic [CHIP_AW-1:0] ofs_i,
  input  logic [LEN_W-1:0]   rem_i,
  output logic [SIZE_W-1:0]  size_o,
  output logic               burst_ok_o
);
  logic [SIZE_W-1:0] room;
  logic [SIZE_W-1:0] clip;

  always_comb begin
    room = SIZE_W'(BUF_BYTES) - SIZE_W'(ofs_i[LOW_W-1:0]);
    if (LEN_W'(room) > rem_i) clip = rem_i[SIZE_W-1:0];
    else                      clip = room;
  end

  generate
    if (BUS_BYTES > 1) begin : g_round
      localparam int BL = $clog2(BUS_BYTES);
      assign size_o = {clip[SIZE_W-1:BL], {BL{1'b0}}};
    end else begin : g_byte
      assign size_o = clip;
    end
  endgenerate

  assign burst_ok_o = rem_i >= LEN_W'(2 * BUS_BYTES);
endmodule

// File: rtl/fbs_advance.sv
// Position update after a successful burst, with chip rollover.
module fbs_advance #(
  parameter int BUF_BYTES = 32,
  parameter int CHIP_AW   = 8,
  parameter int LEN_W     = 16,
  parameter int CHIP_W    = 2,
  localparam int SIZE_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic [CHIP_W-1:0]  chip_i,
  input  logic [CHIP_AW-1:0] ofs_i,
  input  logic [LEN_W-1:0]   rem_i,
  input  logic [LEN_W-1:0]   cnt_i,
  input  logic [SIZE_W-1:0]  size_i,
  output logic [CHIP_W-1:0]  chip_o,
  output logic [CHIP_AW-1:0] ofs_o,
  output logic [LEN_W-1:0]   rem_o,
  output logic [LEN_W-1:0]   cnt_o
);
  logic [CHIP_AW:0] sum;
  logic             wrap;

  always_comb begin
    sum    = {1'b0, ofs_i} + (CHIP_AW+1)'(size_i);
    wrap   = sum[CHIP_AW];
    ofs_o  = wrap ? '0 : sum[CHIP_AW-1:0];
    chip_o = chip_i + CHIP_W'(wrap);
    rem_o  = rem_i - LEN_W'(size_i);
    cnt_o  = cnt_i + LEN_W'(size_i);
  end
endmodule

// File: rtl/flash_burst_splitter.sv
module flash_burst_splitter #(
  parameter int BUF_BYTES = 32,
  parameter int BUS_BYTES = 2,
  parameter int CHIP_AW   = 8,
  parameter int NUM_CHIPS = 2,
  parameter int LEN_W     = 16,
  localparam int CHIP_W   = $clog2(NUM_CHIPS + 1),
  localparam int SIZE_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CHIP_W-1:0]  start_chip,
  input  logic [CHIP_AW-1:0] start_ofs,
  input  logic [LEN_W-1:0]   start_len,
  output logic               busy,
  output logic               burst_valid,
  input  logic               burst_ready,
  output logic [CHIP_W-1:0]  burst_chip,
  output logic [CHIP_AW-1:0] burst_ofs,
  output logic [SIZE_W-1:0]  burst_size,
  output logic [LEN_W-1:0]   burst_src,
  input  logic               burst_done,
  input  logic               burst_err,
  output logic               word_valid,
  input  logic               word_ready,
  output logic [CHIP_W-1:0]  word_chip,
  output logic [CHIP_AW-1:0] word_ofs,
  output logic [LEN_W-1:0]   word_len,
  output logic [LEN_W-1:0]   word_src,
  input  logic               word_done,
  input  logic               word_err,
  input  logic [LEN_W-1:0]   word_count,
  output logic               done,
  output logic               done_err,
  output logic [LEN_W-1:0]   done_count
);
  import fbs_pkg::*;

  fbs_state_t        st_q;
  logic [CHIP_W-1:0]  chip_q;
  logic [CHIP_AW-1:0] ofs_q;
  logic [LEN_W-1:0]   rem_q, cnt_q;
  logic [SIZE_W-1:0]  size_q;
  logic               err_q;

  logic [SIZE_W-1:0]  nx_size;
  logic               can_burst;
  logic [CHIP_W-1:0]  adv_chip;
  logic [CHIP_AW-1:0] adv_ofs;
  logic [LEN_W-1:0]   adv_rem, adv_cnt;

  fbs_sizer #(
    .BUF_BYTES(BUF_BYTES), .BUS_BYTES(BUS_BYTES),
    .CHIP_AW(CHIP_AW), .LEN_W(LEN_W)
  ) u_sizer (
    .ofs_i(ofs_q), .rem_i(rem_q),
    .size_o(nx_size), .burst_ok_o(can_burst)
  );

  fbs_advance #(
    .BUF_BYTES(BUF_BYTES), .CHIP_AW(CHIP_AW),
    .LEN_W(LEN_W), .CHIP_W(CHIP_W)
  ) u_adv (
    .chip_i(chip_q), .ofs_i(ofs_q), .rem_i(rem_q), .cnt_i(cnt_q), .size_i(size_q),
    .chip_o(adv_chip), .ofs_o(adv_ofs), .rem_o(adv_rem), .cnt_o(adv_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      chip_q <= '0;
      ofs_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      size_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          chip_q <= start_chip;
          ofs_q  <= start_ofs;
          rem_q  <= start_len;
          cnt_q  <= '0;
          err_q  <= 1'b0;
          st_q   <= ST_PLAN;
        end
        ST_PLAN: begin
          if (chip_q >= CHIP_W'(NUM_CHIPS)) st_q <= ST_FIN;
          else if (can_burst) begin
            size_q <= nx_size;
            st_q   <= ST_BURST;
          end
          else if (rem_q != '0) st_q <= ST_WORD;
          else                  st_q <= ST_FIN;
        end
        ST_BURST: if (burst_ready) st_q <= ST_BWAIT;
        ST_BWAIT: if (burst_done) begin
          if (burst_err) begin
            err_q <= 1'b1;
            st_q  <= ST_FIN;
          end else begin
            chip_q <= adv_chip;
            ofs_q  <= adv_ofs;
            rem_q  <= adv_rem;
            cnt_q  <= adv_cnt;
            st_q   <= ST_PLAN;
          end
        end
        ST_WORD: if (word_ready) st_q <= ST_WWAIT;
        ST_WWAIT: if (word_done) begin
          cnt_q <= cnt_q + word_count;
          err_q <= word_err;
          st_q  <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign burst_valid = (st_q == ST_BURST);
  assign burst_chip  = chip_q;
  assign burst_ofs   = ofs_q;
  assign burst_size  = size_q;
  assign burst_src   = cnt_q;
  assign word_valid  = (st_q == ST_WORD);
  assign word_chip   = chip_q;
  assign word_ofs    = ofs_q;
  assign word_len    = rem_q;
  assign word_src    = cnt_q;
  assign done        = (st_q == ST_FIN);
  assign done_err    = err_q;
  assign done_count  = cnt_q;
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int BUF_BYTES = 32,
  parameter int BUS_BYTES = 2,
  parameter int CHIP_AW   = 8,
  parameter int NUM_CHIPS = 2,
  parameter int LEN_W     = 16,
  localparam int CHIP_W   = $clog2(NUM_CHIPS + 1),
  localparam int SIZE_W   = $clog2(BUF_BYTES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               burst_valid,
  input logic               burst_ready,
  input logic [CHIP_W-1:0]  burst_chip,
  input logic [CHIP_AW-1:0] burst_ofs,
  input logic [SIZE_W-1:0]  burst_size,
  input logic               word_valid,
  input logic               word_ready,
  input logic [CHIP_W-1:0]  word_chip,
  input logic [LEN_W-1:0]   word_len,
  input logic               done
);
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (int'(burst_ofs) % BUF_BYTES) + int'(burst_size) <= BUF_BYTES);

  p_whole_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (burst_size != '0) && (int'(burst_size) % BUS_BYTES == 0));

  p_burst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_ofs) &&
                                    $stable(burst_size) && $stable(burst_chip));

  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_len));

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({burst_valid, word_valid, done}));

  p_chip_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid |-> int'(burst_chip) < NUM_CHIPS) and (word_valid |-> int'(word_chip) < NUM_CHIPS));

  p_short_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_len != '0) && (int'(word_len) < 2 * BUS_BYTES));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind flash_burst_splitter fbs_checker #(
  .BUF_BYTES(BUF_BYTES), .BUS_BYTES(BUS_BYTES), .CHIP_AW(CHIP_AW),
  .NUM_CHIPS(NUM_CHIPS), .LEN_W(LEN_W)
) u_fbs_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_chip(burst_chip),
  .burst_ofs(burst_ofs), .burst_size(burst_size),
  .word_valid(word_valid), .word_ready(word_ready), .word_chip(word_chip),
  .word_len(word_len), .done(done)
);

// File: tb/tb_flash_burst_splitter.sv
`timescale 1ns/1ps
module tb_flash_burst_splitter;
  localparam int BUF  = 32;
  localparam int BUS  = 2;
  localparam int AW   = 8;
  localparam int NCH  = 2;
  localparam int LW   = 16;
  localparam int CW   = $clog2(NCH + 1);
  localparam int SW   = $clog2(BUF + 1);
  localparam int CHSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] start_chip = '0;
  logic [AW-1:0] start_ofs = '0;
  logic [LW-1:0] start_len = '0;
  logic busy, burst_valid, word_valid, done, done_err;
  logic burst_ready = 1'b0, burst_done = 1'b0, burst_err = 1'b0;
  logic word_ready = 1'b0, word_done = 1'b0, word_err = 1'b0;
  logic [LW-1:0] word_count = '0;
  logic [CW-1:0] burst_chip, word_chip;
  logic [AW-1:0] burst_ofs, word_ofs;
  logic [SW-1:0] burst_size;
  logic [LW-1:0] burst_src, word_len, word_src, done_count;

  always #4 clk = ~clk;

  flash_burst_splitter #(.BUF_BYTES(BUF), .BUS_BYTES(BUS), .CHIP_AW(AW),
                         .NUM_CHIPS(NCH), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_chip(start_chip),
    .start_ofs(start_ofs), .start_len(start_len), .busy(busy),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_chip(burst_chip),
    .burst_ofs(burst_ofs), .burst_size(burst_size), .burst_src(burst_src),
    .burst_done(burst_done), .burst_err(burst_err),
    .word_valid(word_valid), .word_ready(word_ready), .word_chip(word_chip),
    .word_ofs(word_ofs), .word_len(word_len), .word_src(word_src),
    .word_done(word_done), .word_err(word_err), .word_count(word_count),
    .done(done), .done_err(done_err), .done_count(done_count));

  int n_chk = 0;
  int n_fail = 0;
  bit in_op = 1'b0;
  int cyc = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Every clock: outside an operation the block is quiet (R2, R5).
  always @(negedge clk) if (rst_n && !in_op)
    chk(!busy && !burst_valid && !word_valid && !done, "R2 idle quiet",
        int'({busy, burst_valid, word_valid, done}), 0);

  // reference plan
  int e_chip[$], e_ofs[$], e_size[$], e_src[$];

  task automatic run_op(input int ofs, input int len, input int chip, input int err_at,
                        input int tail_short, input bit tail_err, input bit probe);
    int o, l, c, cnt, sz, bi, guard;
    bit e_err, e_tail, got_tail, fin;
    int t_chip, t_ofs, t_len, t_src, e_total;
    e_chip.delete(); e_ofs.delete(); e_size.delete(); e_src.delete();
    o = ofs; l = len; c = chip; cnt = 0; e_err = 0; e_tail = 0;
    t_chip = 0; t_ofs = 0; t_len = 0; t_src = 0;
    while (c < NCH && l >= 2 * BUS) begin
      sz = BUF - (o % BUF);
      if (sz > l) sz = l;
      sz = sz - (sz % BUS);
      e_chip.push_back(c); e_ofs.push_back(o); e_size.push_back(sz); e_src.push_back(cnt);
      if (e_size.size() - 1 == err_at) begin e_err = 1; break; end
      o += sz; l -= sz; cnt += sz;
      if (o >= CHSZ) begin c++; o = 0; end
    end
    if (!e_err && c < NCH && l > 0) begin
      e_tail = 1; t_chip = c; t_ofs = o; t_len = l; t_src = cnt;
      cnt += l - tail_short; e_err = tail_err;
    end
    e_total = cnt;

    in_op = 1'b1;
    @(negedge clk);
    start = 1; start_chip = CW'(chip); start_ofs = AW'(ofs); start_len = LW'(len);
    @(negedge clk);
    start = 0;
    chk(busy, "R2 busy after start", int'(busy), 1);
    bi = 0; got_tail = 0; fin = 0; guard = 0;
    while (!fin && guard < 3000) begin
      guard++;
      if (burst_valid) begin
        if (bi < e_size.size()) begin
          chk(int'(burst_size) == e_size[bi], "R4 burst size", int'(burst_size), e_size[bi]);
          chk(int'(burst_ofs) == e_ofs[bi], "R6 R7 burst offset", int'(burst_ofs), e_ofs[bi]);
          chk(int'(burst_chip) == e_chip[bi], "R7 burst chip", int'(burst_chip), e_chip[bi]);
          chk(int'(burst_src) == e_src[bi], "R6 burst src", int'(burst_src), e_src[bi]);
        end else chk(0, "R3 R8 unexpected burst", bi, e_size.size());
        repeat (bi % 3) begin
          @(negedge clk);
          chk(burst_valid && int'(burst_size) == e_size[bi], "R5 held under stall",
              int'(burst_valid), 1);
        end
        burst_ready = 1;
        @(negedge clk); burst_ready = 0;
        @(negedge clk);
        chk(!burst_valid && !word_valid, "R5 one outstanding", int'({burst_valid, word_valid}), 0);
        if (probe && bi == 0) begin
          start = 1; start_chip = '0; start_ofs = AW'(4); start_len = LW'(6);
          @(negedge clk); start = 0;
          chk(busy && !burst_valid, "R2 start ignored while busy", int'(burst_valid), 0);
        end
        burst_done = 1; burst_err = (bi == err_at);
        @(negedge clk); burst_done = 0; burst_err = 0;
        bi++;
      end else if (word_valid) begin
        chk(e_tail && !got_tail, "R10 tail expected", int'(got_tail), 0);
        chk(int'(word_len) == t_len, "R10 tail len", int'(word_len), t_len);
        chk(int'(word_ofs) == t_ofs && int'(word_chip) == t_chip, "R10 tail place",
            int'(word_ofs), t_ofs);
        chk(int'(word_src) == t_src, "R10 tail src", int'(word_src), t_src);
        @(negedge clk);
        chk(word_valid, "R5 word held", int'(word_valid), 1);
        word_ready = 1;
        @(negedge clk); word_ready = 0;
        word_done = 1; word_err = tail_err; word_count = LW'(t_len - tail_short);
        @(negedge clk); word_done = 0; word_err = 0; word_count = '0;
        got_tail = 1;
      end else if (done) begin
        chk(done_err == e_err, "R9 R10 final status", int'(done_err), int'(e_err));
        chk(int'(done_count) == e_total, "R6 R9 R10 R11 done count", int'(done_count), e_total);
        chk(bi == e_size.size(), "R3 R8 R9 burst total", bi, e_size.size());
        chk(got_tail == e_tail, "R8 R10 tail issued", int'(got_tail), int'(e_tail));
        @(negedge clk);
        chk(!done && !busy, "R11 done single cycle", int'(done), 0);
        fin = 1;
      end else @(negedge clk);
    end
    chk(fin, "R11 operation finished", int'(fin), 1);
    in_op = 1'b0;
  endtask

  initial begin
    in_op = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !burst_valid && !word_valid && !done, "R1 reset state",
        int'({busy, burst_valid, word_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 after release", int'(busy), 0);
    in_op = 1'b0;
    // R4 window split and clipping, with a start probe for R2
    run_op(6, 70, 0, -1, 0, 0, 1);
    // R3 R10 burst then one-byte tail
    run_op(10, 9, 0, -1, 0, 0, 0);
    // R7 rollover into the next chip
    run_op(240, 40, 0, -1, 0, 0, 0);
    // R8 end at the last chip, leftover dropped
    run_op(224, 100, 1, -1, 0, 0, 0);
    // R9 error on the second burst
    run_op(0, 96, 0, 1, 0, 0, 0);
    // R9 error on the first burst
    run_op(32, 20, 1, 0, 0, 0, 0);
    // R10 tail only, short count and error reported
    run_op(4, 3, 0, -1, 1, 1, 0);
    // R11 zero length
    run_op(8, 0, 0, -1, 0, 0, 0);
    // R4 exactly two words at the end of a window
    run_op(28, 5, 1, -1, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule